// File: doc/BRIEF.md
# Directory Coherence Controller

This controller sits beside main memory and keeps the sharing state of a small set of memory blocks for `NPROC` processors. For each block it stores a full presence vector, with one bit per processor, and a single dirty flag. Processors send three kinds of request, each tagged with the requester's ID: read miss, write miss, and write to a line they hold clean. The controller answers each request with a sequence of outgoing messages. These are recalls to a dirty owner, invalidations to sharers, and a final data reply. It also drives read and write commands toward a memory array.

Only one request is in service at a time. When a request arrives, the controller latches it together with the block's directory entry. It then works through invalidations or a recall and counts the acknowledgements still outstanding. Data returned by a recall is written back to memory before the reply. The directory entry is rewritten when the reply handshake completes, and the controller then accepts the next request.

Top module: `dir_ctrl`

## Requirements
- R1: After reset, every presence bit and every dirty flag is clear. A read miss (request code 0) to any block then produces only a data reply (message code 3) carrying the memory content, with no recall or invalidation.
- R2: A read miss to a block whose dirty flag is clear reads memory and returns one data reply to the requester with that data. It then sets the requester's presence bit and leaves the other sharers in place.
- R3: A read miss to a dirty block first sends a shared-recall (message code 0) to the owner and waits for its acknowledgement. It then writes the acknowledged data to memory and replies to the requester with that data. Afterwards the block is clean and both processors are sharers.
- R4: A write miss (request code 1) to a clean block sends one invalidation (message code 2) to each sharer other than the requester. These go out in ascending processor order, one per cycle when the receiver is ready. The controller waits for every acknowledgement and then replies with memory data. Afterwards the requester is the only sharer and the block is dirty.
- R5: A write miss to a dirty block sends an invalidating recall (message code 1) to the owner and waits for the acknowledgement. It writes the returned data to memory and replies with that data to the requester, which becomes the sole dirty owner.
- R6: A write to a line held clean (request code 2) invalidates all other sharers in the same order and manner as R4. After the acknowledgements it replies to the requester, which becomes the sole dirty owner.
- R7: From acceptance until the reply handshake, `busy_o` is high and `req_ready_o` is low. The reply is sent only after all acknowledgements for the request have arrived.
- R8: An outgoing message that is not accepted keeps its valid, type, destination and data unchanged until it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller can accept a request |
| req_type_i | input | 2 | 0 read miss, 1 write miss, 2 write to clean line |
| req_pid_i | input | $clog2(NPROC) | Requesting processor |
| req_blk_i | input | $clog2(NBLK) | Block index |
| busy_o | output | 1 | A request is in service |
| msg_valid_o | output | 1 | Outgoing message present |
| msg_ready_i | input | 1 | Network accepts the message |
| msg_type_o | output | 2 | 0 shared recall, 1 invalidating recall, 2 invalidate, 3 data |
| msg_dst_o | output | $clog2(NPROC) | Destination processor |
| msg_blk_o | output | $clog2(NBLK) | Block index |
| msg_data_o | output | DW | Data for reply messages |
| ack_valid_i | input | 1 | Acknowledgement from a processor |
| ack_pid_i | input | $clog2(NPROC) | Acknowledging processor |
| ack_data_i | input | DW | Line data carried by a recall acknowledgement |
| mem_rd_o | output | 1 | Memory read command |
| mem_wr_o | output | 1 | Memory write command |
| mem_addr_o | output | $clog2(NBLK) | Memory block address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data, same cycle |

## Verification
The directory state is not visible at the ports, so errors in it show up in how the next request to the same block is answered. A lost presence bit shows up as a missing invalidation. A stale dirty flag shows up as a spurious or missing recall, or as reply data taken from memory instead of from the owner. All of these appear within one request of the corrupting update. Sequencing faults appear at once in the message stream: the wrong order, a skipped requester, a reply sent before the acknowledgements are in, or a message that changes while stalled.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    REQ_RD_MISS = 2'd0,
    REQ_WR_MISS = 2'd1,
    REQ_WR_HIT  = 2'd2
  } req_e;

  typedef enum logic [1:0] {
    MSG_RECALL_SH  = 2'd0,
    MSG_RECALL_INV = 2'd1,
    MSG_INVAL      = 2'd2,
    MSG_DATA       = 2'd3
  } msg_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_INV, ST_RECALL, ST_WAIT, ST_WB, ST_REPLY
  } state_e;
endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
    any_o = |req_i;
    if (any_o) gnt_o[idx_o] = 1'b1;
  end
endmodule

// File: rtl/dir_store.sv
module dir_store #(
  parameter int NPROC = 4,
  parameter int NBLK  = 4,
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BW-1:0]    rd_blk_i,
  output logic [NPROC-1:0] rd_pres_o,
  output logic             rd_dirty_o,
  input  logic             we_i,
  input  logic [BW-1:0]    wr_blk_i,
  input  logic [NPROC-1:0] wr_pres_i,
  input  logic             wr_dirty_i
);
  logic [NPROC-1:0] pres_q [NBLK];
  logic [NBLK-1:0]  dirty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NBLK; b++) pres_q[b] <= '0;
      dirty_q <= '0;
    end else if (we_i) begin
      pres_q[wr_blk_i]  <= wr_pres_i;
      dirty_q[wr_blk_i] <= wr_dirty_i;
    end
  end

  assign rd_pres_o  = pres_q[rd_blk_i];
  assign rd_dirty_o = dirty_q[rd_blk_i];

  AST_DIRTY_SOLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && wr_dirty_i |-> $countones(wr_pres_i) == 1); // R5
  AST_DIRTY_STORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_dirty_o |-> $countones(rd_pres_o) == 1); // R4
endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
  import dir_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 4,
  parameter int DW    = 8,
  localparam int PW = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int CW = $clog2(NPROC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [1:0]    req_type_i,
  input  logic [PW-1:0] req_pid_i,
  input  logic [BW-1:0] req_blk_i,
  output logic          busy_o,
  output logic          msg_valid_o,
  input  logic          msg_ready_i,
  output logic [1:0]    msg_type_o,
  output logic [PW-1:0] msg_dst_o,
  output logic [BW-1:0] msg_blk_o,
  output logic [DW-1:0] msg_data_o,
  input  logic          ack_valid_i,
  input  logic [PW-1:0] ack_pid_i,
  input  logic [DW-1:0] ack_data_i,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [BW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  state_e           state_q;
  req_e             cur_type_q;
  logic [PW-1:0]    cur_pid_q, cur_owner_q;
  logic [BW-1:0]    cur_blk_q;
  logic [NPROC-1:0] cur_pres_q, inv_mask_q;
  logic [CW-1:0]    outs_q;
  logic [DW-1:0]    rec_data_q;
  logic             use_rec_q;

  logic [NPROC-1:0] rd_pres, req_bit, cur_bit, inv_gnt, own_gnt;
  logic             rd_dirty, inv_any, own_any;
  logic [PW-1:0]    inv_idx, own_idx;
  logic             msg_hs, issue, dir_we;
  logic [NPROC-1:0] new_pres;

  dir_store #(.NPROC(NPROC), .NBLK(NBLK)) u_store (
    .clk_i, .rst_ni,
    .rd_blk_i(req_blk_i), .rd_pres_o(rd_pres), .rd_dirty_o(rd_dirty),
    .we_i(dir_we), .wr_blk_i(cur_blk_q), .wr_pres_i(new_pres),
    .wr_dirty_i(cur_type_q != REQ_RD_MISS)
  );

  prio_pick #(.N(NPROC)) u_inv_pick (
    .req_i(inv_mask_q), .gnt_o(inv_gnt), .idx_o(inv_idx), .any_o(inv_any));

  prio_pick #(.N(NPROC)) u_own_pick (
    .req_i(rd_pres), .gnt_o(own_gnt), .idx_o(own_idx), .any_o(own_any));

  always_comb begin
    req_bit = '0;
    req_bit[req_pid_i] = 1'b1;
    cur_bit = '0;
    cur_bit[cur_pid_q] = 1'b1;
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign req_ready_o = !busy_o;
  assign new_pres    = (cur_type_q == REQ_RD_MISS) ? (cur_pres_q | cur_bit) : cur_bit;

  always_comb begin
    msg_valid_o = 1'b0;
    msg_type_o  = MSG_DATA;
    msg_dst_o   = cur_pid_q;
    msg_data_o  = '0;
    mem_rd_o    = 1'b0;
    mem_wr_o    = 1'b0;
    unique case (state_q)
      ST_INV: begin
        msg_valid_o = inv_any;
        msg_type_o  = MSG_INVAL;
        msg_dst_o   = inv_idx;
      end
      ST_RECALL: begin
        msg_valid_o = 1'b1;
        msg_type_o  = (cur_type_q == REQ_RD_MISS) ? MSG_RECALL_SH : MSG_RECALL_INV;
        msg_dst_o   = cur_owner_q;
      end
      ST_WB: mem_wr_o = 1'b1;
      ST_REPLY: begin
        msg_valid_o = 1'b1;
        msg_data_o  = use_rec_q ? rec_data_q : mem_rdata_i;
        mem_rd_o    = !use_rec_q;
      end
      default: ;
    endcase
  end

  assign msg_blk_o   = cur_blk_q;
  assign mem_addr_o  = cur_blk_q;
  assign mem_wdata_o = rec_data_q;
  assign msg_hs      = msg_valid_o && msg_ready_i;
  assign issue       = msg_hs && (state_q == ST_INV || state_q == ST_RECALL);
  assign dir_we      = msg_hs && (state_q == ST_REPLY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cur_type_q  <= REQ_RD_MISS;
      cur_pid_q   <= '0;
      cur_owner_q <= '0;
      cur_blk_q   <= '0;
      cur_pres_q  <= '0;
      inv_mask_q  <= '0;
      outs_q      <= '0;
      rec_data_q  <= '0;
      use_rec_q   <= 1'b0;
    end else begin
      outs_q <= outs_q + CW'(issue) - CW'(ack_valid_i);
      if (ack_valid_i && use_rec_q) rec_data_q <= ack_data_i;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          cur_type_q  <= req_e'(req_type_i);
          cur_pid_q   <= req_pid_i;
          cur_blk_q   <= req_blk_i;
          cur_pres_q  <= rd_pres;
          cur_owner_q <= own_idx;
          use_rec_q   <= rd_dirty;
          inv_mask_q  <= rd_pres & ~req_bit;
          if (rd_dirty)                            state_q <= ST_RECALL;
          else if (req_e'(req_type_i) == REQ_RD_MISS) state_q <= ST_REPLY;
          else                                     state_q <= ST_INV;
        end
        ST_INV: begin
          if (msg_hs) inv_mask_q <= inv_mask_q & ~inv_gnt;
          if (!inv_any) state_q <= ST_WAIT;
        end
        ST_RECALL: if (msg_hs) state_q <= ST_WAIT;
        ST_WAIT: if (outs_q == '0) state_q <= use_rec_q ? ST_WB : ST_REPLY;
        ST_WB: state_q <= ST_REPLY;
        ST_REPLY: if (msg_hs) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_MSG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_type_o)
      && $stable(msg_dst_o) && $stable(msg_data_o)); // R8
  AST_INV_NOT_SELF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && msg_type_o == MSG_INVAL |-> msg_dst_o != cur_pid_q); // R4
  AST_ACK_EXPECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_i |-> outs_q != '0); // R7
  AST_REPLY_DRAINED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && msg_type_o == MSG_DATA |-> outs_q == '0); // R7
  AST_RECALL_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_i && use_rec_q |-> ack_pid_i == cur_owner_q); // R3
  AST_OWNER_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_dirty |-> own_any && (own_gnt == rd_pres)); // R5
endmodule

// File: tb/tb_dir_ctrl.sv
module tb_dir_ctrl;
  localparam int NP = 4, NB = 4, DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_type = '0;
  logic [1:0] req_pid = '0, req_blk = '0;
  logic busy, msg_valid, msg_ready = 1'b1;
  logic [1:0] msg_type, msg_dst, msg_blk;
  logic [DW-1:0] msg_data;
  logic ack_valid = 1'b0;
  logic [1:0] ack_pid = '0;
  logic [DW-1:0] ack_data = '0;
  logic mem_rd, mem_wr;
  logic [1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [DW-1:0] mem [NB];

  always #5 clk = ~clk;
  assign mem_rdata = mem[mem_addr];

  dir_ctrl #(.NPROC(NP), .NBLK(NB), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_type_i(req_type), .req_pid_i(req_pid), .req_blk_i(req_blk), .busy_o(busy),
    .msg_valid_o(msg_valid), .msg_ready_i(msg_ready), .msg_type_o(msg_type),
    .msg_dst_o(msg_dst), .msg_blk_o(msg_blk), .msg_data_o(msg_data),
    .ack_valid_i(ack_valid), .ack_pid_i(ack_pid), .ack_data_i(ack_data),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata));

  int checks = 0, errors = 0, cyc = 0, seq = 0;
  int nlog = 0;
  logic [1:0] lt [16];
  logic [1:0] ld [16];
  logic [1:0] lb [16];
  logic [DW-1:0] ldat [16];
  int lcyc [16];
  int af_h = 0, af_t = 0;
  logic [1:0] af_pid [16];
  logic [DW-1:0] af_dat [16];
  int af_tm [16];
  bit reply_seen = 0, in_req = 0, stall_en = 0;
  int busy_err = 0, hold_err = 0, hold_evt = 0;
  logic prev_stall = 1'b0;
  logic [1:0] p_type, p_dst;
  logic [DW-1:0] p_data;

  logic [NP-1:0] ref_pres [NB];
  logic ref_dirty [NB];
  logic [DW-1:0] exp_mem [NB];

  function automatic logic [DW-1:0] rv(int s, int b);
    return DW'((s * 13 + b * 5 + 64) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // network model: ready pattern, acks, logging, memory writes
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      msg_ready = stall_en ? (cyc % 3 != 0) : 1'b1;
      if (af_h != af_t && af_tm[af_h % 16] <= cyc) begin
        ack_valid = 1'b1;
        ack_pid   = af_pid[af_h % 16];
        ack_data  = af_dat[af_h % 16];
        af_h++;
      end else ack_valid = 1'b0;
      #1;
      if (rst_n) begin
        if (prev_stall) begin
          hold_evt++;
          if (!msg_valid || msg_type != p_type || msg_dst != p_dst || msg_data != p_data)
            hold_err++;
        end
        prev_stall = msg_valid && !msg_ready;
        p_type = msg_type; p_dst = msg_dst; p_data = msg_data;
        if (in_req && (req_ready || !busy)) busy_err++;
        if (msg_valid && msg_ready) begin
          lt[nlog % 16] = msg_type; ld[nlog % 16] = msg_dst;
          lb[nlog % 16] = msg_blk; ldat[nlog % 16] = msg_data;
          lcyc[nlog % 16] = cyc;
          nlog++;
          if (msg_type != 2'd3) begin
            af_pid[af_t % 16] = msg_dst;
            af_dat[af_t % 16] = (msg_type == 2'd2) ? '0 : rv(seq, int'(msg_blk));
            af_tm[af_t % 16]  = cyc + 2;
            af_t++;
          end else begin
            reply_seen = 1;
            in_req = 0;
          end
        end
        if (mem_wr) mem[mem_addr] = mem_wdata;
      end
      if (cyc > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic do_op(input int t, input int pid, input int blk, input string tag);
    logic [1:0] et [8];
    logic [1:0] ed [8];
    int ne = 0, owner = 0, ninv = 0;
    logic [DW-1:0] edata;
    bit ok;
    seq++;
    for (int p = 0; p < NP; p++) if (ref_pres[blk][p]) owner = p;
    if (ref_dirty[blk]) begin
      et[0] = (t == 0) ? 2'd0 : 2'd1; ed[0] = 2'(owner); ne = 1;
      edata = rv(seq, blk);
      exp_mem[blk] = edata;
    end else begin
      if (t != 0)
        for (int p = 0; p < NP; p++)
          if (ref_pres[blk][p] && p != pid) begin et[ne] = 2'd2; ed[ne] = 2'(p); ne++; ninv++; end
      edata = exp_mem[blk];
    end
    et[ne] = 2'd3; ed[ne] = 2'(pid); ne++;
    nlog = 0; reply_seen = 0;
    @(negedge clk);
    req_type = 2'(t); req_pid = 2'(pid); req_blk = 2'(blk); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1 in_req = 1;
    @(negedge clk); req_valid = 1'b0;
    while (!reply_seen) @(negedge clk);
    repeat (2) @(negedge clk);
    ok = (nlog == ne);
    for (int k = 0; k < ne && k < nlog; k++)
      if (lt[k] != et[k] || ld[k] != ed[k] || lb[k] != 2'(blk)) ok = 0;
    chk(ok, {tag, " message sequence"}, nlog, ne);
    chk(ldat[(nlog + 15) % 16] == edata, {tag, " reply data"}, int'(ldat[(nlog + 15) % 16]), int'(edata));
    chk(mem[blk] == exp_mem[blk], {tag, " memory content"}, int'(mem[blk]), int'(exp_mem[blk]));
    if (!stall_en && ninv > 1) begin
      ok = 1;
      for (int k = 0; k + 1 < ninv; k++) if (lcyc[k + 1] - lcyc[k] != 1) ok = 0;
      chk(ok, {tag, " one invalidate per cycle"}, lcyc[1] - lcyc[0], 1);
    end
    if (t == 0) begin
      ref_pres[blk][pid] = 1'b1; ref_dirty[blk] = 1'b0;
    end else begin
      ref_pres[blk] = '0; ref_pres[blk][pid] = 1'b1; ref_dirty[blk] = 1'b1;
    end
  endtask

  initial begin
    for (int b = 0; b < NB; b++) begin
      mem[b] = DW'(b * 17 + 5); exp_mem[b] = mem[b];
      ref_pres[b] = '0; ref_dirty[b] = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk(!busy && !msg_valid, "R1 outputs idle in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !busy && !msg_valid && !mem_wr, "R1 ready after reset", int'(req_ready), 1);
    for (int b = 0; b < NB; b++) do_op(0, 2, b, "R1");
    for (int pass = 0; pass < 2; pass++) begin
      stall_en = (pass == 1);
      for (int b = 0; b < NB; b++)
        for (int n = 0; n < 40; n++) begin
          int pid, owner, t;
          string tag;
          pid = (n * 3 + n / 4 + b) % NP;
          owner = -1;
          for (int p = 0; p < NP; p++) if (ref_dirty[b] && ref_pres[b][p]) owner = p;
          if (owner == pid) pid = (pid + 1) % NP;
          if (ref_pres[b][pid]) t = 2;
          else t = (n % 3 == 0) ? 1 : 0;
          if (t == 2) tag = "R6";
          else if (t == 0) tag = ref_dirty[b] ? "R3" : "R2";
          else tag = ref_dirty[b] ? "R5" : "R4";
          do_op(t, pid, b, tag);
        end
    end
    chk(busy_err == 0, "R7 busy held, ready low during service", busy_err, 0);
    chk(hold_err == 0, "R8 stalled message stable", hold_err, 0);
    chk(hold_evt > 0, "R8 stall exercised", hold_evt, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule